// File: doc/BRIEF.md
# Framed Serial ADC Readout Controller

This block is the host side of a serial analog-to-digital converter link that is framed by a single conversion strobe. When the host pulses a start request, the controller raises the frame line, which starts a conversion in the converter. It holds the line high for a programmable number of system clock cycles. It then drops the line and runs a divided shift clock for exactly twelve periods. On each falling shift-clock edge it presents the next bit of a 2-bit channel word, and on each rising edge it captures the next bit of the converter's result.

The converter applies a channel word to the conversion that follows the one being read. The controller therefore keeps the word it sent in the previous frame and labels each result with it. The 12-bit straight-binary result and its channel label are registered and stay constant until the next completion pulse. Each completion is signalled by a one-cycle done strobe.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, frame_o, sck_o, sdi_o, busy_o and done_o are 0, and result_o and result_chan_o are all zeros.
- R2: A start_i seen while idle latches chan_i. frame_o and busy_o are 1 in the following cycle. A start_i seen while busy is ignored: it starts no frame and changes no channel word.
- R3: frame_o stays high for exactly CONV_CYCLES system clock cycles per readout, and sck_o is low for all of that time.
- R4: sck_o idles low. It toggles only while busy with frame_o low. Each high and each low phase lasts SCK_DIV/2 system cycles, so consecutive rising edges are SCK_DIV cycles apart. The first rising edge comes SCK_DIV/2 cycles after frame_o falls.
- R5: Each readout produces exactly RES_W (12) rising edges of sck_o, never more.
- R6: sdo_i is sampled at each rising sck_o edge. The first sample becomes result_o bit 11 and the last becomes bit 0, and the code is passed through unchanged as straight binary (000h to FFFh).
- R7: sdi_o carries the latched channel word, bit 1 first and then bit 0. It is valid before the first rising sck_o edge, changes only together with a falling sck_o edge, and is 0 for rising edges 3 to 12.
- R8: done_o is a single-cycle pulse. It rises one cycle after the falling edge that follows the 12th rising edge, and busy_o is already 0 in that cycle.
- R9: result_o and result_chan_o change only in a cycle where done_o is 1.
- R10: result_chan_o equals the channel word sent in the previous readout frame, because that word selected the conversion now being read. It is 0 for the first readout after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Readout request, taken only when idle |
| chan_i | input | CFG_W | Channel word sent to the converter in this frame |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | RES_W | Captured conversion code, MSB first on the wire |
| result_chan_o | output | CFG_W | Channel word that selected the captured conversion |
| frame_o | output | 1 | Conversion strobe to the converter; rising edge starts a conversion |
| sck_o | output | 1 | Divided shift clock, idles low |
| sdi_o | output | 1 | Serial channel word to the converter |
| sdo_i | input | 1 | Serial result from the converter |

## Verification
The checks assume that SCK_DIV is even and at least 2 and that sdo_i is stable around every rising shift-clock edge. The bench guarantees the second condition with a behavioural converter model. The model changes its data line only at the frame fall and at falling shift-clock edges, which are SCK_DIV/2 system cycles away from any sampling edge. start_i and chan_i are driven away from the active clock edge. Extra start pulses are placed deliberately inside busy frames, so the ignore rule is exercised while the assertions about frame, clock and channel-word timing are active.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } fsm_state_e;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int unsigned SCK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = SCK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == HALF_M1);
  // strobes mark the system edge at which sck_q toggles
  assign rise_o = wrap && !sck_q;
  assign fall_o = wrap && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_unit.sv
module adc_shift_unit #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned CFG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sdo_i,
  output logic             sdi_o,
  output logic [RES_W-1:0] rx_o
);
  logic [CFG_W-1:0] tx_q;
  logic [RES_W-1:0] rx_q;

  assign sdi_o = tx_q[CFG_W-1];
  assign rx_o  = rx_q;

  // outgoing word: advance on falling shift edge, zero-fill behind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= cfg_i;
    else if (fall_i)  tx_q <= tx_q << 1;
  end

  // incoming word: capture on rising shift edge, MSB arrives first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_q <= '0;
    else if (load_i)  rx_q <= '0;
    else if (rise_i)  rx_q <= {rx_q[RES_W-2:0], sdo_i};
  end
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_frame_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned RES_W       = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic load_o,
  output logic frame_o,
  output logic sck_en_o,
  output logic busy_o,
  output logic finish_o
);
  localparam int unsigned WW = $clog2(CONV_CYCLES + 1);
  localparam int unsigned BW = $clog2(RES_W + 1);
  localparam logic [WW-1:0] WAIT_INIT = WW'(CONV_CYCLES - 1);
  localparam logic [BW-1:0] BITS_ALL  = BW'(RES_W);

  fsm_state_e    state_q, state_d;
  logic [WW-1:0] wait_q, wait_d;
  logic [BW-1:0] bits_q, bits_d;

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign frame_o  = (state_q == ST_CONV);
  assign sck_en_o = (state_q == ST_SHIFT);
  assign busy_o   = (state_q != ST_IDLE);
  assign finish_o = (state_q == ST_SHIFT) && fall_i && (bits_q == BITS_ALL);

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    bits_d  = bits_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CONV;
          wait_d  = WAIT_INIT;
        end
      end
      ST_CONV: begin
        if (wait_q == '0) begin
          state_d = ST_SHIFT;
          bits_d  = '0;
        end else begin
          wait_d = wait_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (rise_i) bits_d = bits_q + 1'b1;
        if (finish_o) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      bits_q  <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      bits_q  <= bits_d;
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned SCK_DIV     = 4,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned CFG_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] chan_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic [CFG_W-1:0] result_chan_o,
  output logic             frame_o,
  output logic             sck_o,
  output logic             sdi_o,
  input  logic             sdo_i
);
  logic             load, sck_en, rise, fall, finish;
  logic [RES_W-1:0] rx;
  logic [CFG_W-1:0] chan_q, prev_chan_q, tag_q;
  logic [RES_W-1:0] result_q;
  logic             done_q;

  adc_frame_fsm #(
    .CONV_CYCLES(CONV_CYCLES),
    .RES_W      (RES_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .load_o  (load),
    .frame_o (frame_o),
    .sck_en_o(sck_en),
    .busy_o  (busy_o),
    .finish_o(finish)
  );

  adc_sck_gen #(
    .SCK_DIV(SCK_DIV)
  ) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sck_en),
    .sck_o (sck_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adc_shift_unit #(
    .RES_W(RES_W),
    .CFG_W(CFG_W)
  ) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cfg_i (chan_i),
    .rise_i(rise),
    .fall_i(fall),
    .sdo_i (sdo_i),
    .sdi_o (sdi_o),
    .rx_o  (rx)
  );

  // converter pipeline: word sent now selects the next conversion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q      <= '0;
      prev_chan_q <= '0;
      tag_q       <= '0;
      result_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= finish;
      if (load) chan_q <= chan_i;
      if (finish) begin
        result_q    <= rx;
        tag_q       <= prev_chan_q;
        prev_chan_q <= chan_q;
      end
    end
  end

  assign done_o        = done_q;
  assign result_o      = result_q;
  assign result_chan_o = tag_q;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned CFG_W       = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic [CFG_W-1:0] result_chan_o,
  input logic             frame_o,
  input logic             sck_o,
  input logic             sdi_o
);
  int unsigned hi_cnt;
  int unsigned rise_cnt;
  logic        sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= 0;
      rise_cnt <= 0;
      sck_d    <= 1'b0;
    end else begin
      sck_d  <= sck_o;
      hi_cnt <= frame_o ? hi_cnt + 1 : 0;
      if (frame_o)              rise_cnt <= 0;
      else if (sck_o && !sck_d) rise_cnt <= rise_cnt + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!frame_o && !sck_o)); // R4
  AST_SCK_LOW_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !sck_o); // R3
  AST_CONV_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_o) |-> (hi_cnt == CONV_CYCLES)); // R3
  AST_RISE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rise_cnt == RES_W)); // R5
  AST_SDI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sck_o && $past(sck_o)) |-> $stable(sdi_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(result_chan_o))); // R9
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
  .CONV_CYCLES(CONV_CYCLES),
  .RES_W      (RES_W),
  .CFG_W      (CFG_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o),
  .result_chan_o(result_chan_o),
  .frame_o      (frame_o),
  .sck_o        (sck_o),
  .sdi_o        (sdi_o)
);

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;
  localparam int unsigned CONV  = 20;
  localparam int unsigned DIV   = 4;
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned RW    = 12;
  localparam int unsigned CW    = 2;
  localparam longint      CLK_T = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] chan_i = '0;
  logic          busy_o, done_o, frame_o, sck_o, sdi_o;
  logic          sdo_i = 1'b0;
  logic [RW-1:0] result_o;
  logic [CW-1:0] result_chan_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc   = 0;

  adc_frame_ctrl #(
    .CONV_CYCLES(CONV),
    .SCK_DIV    (DIV),
    .RES_W      (RW),
    .CFG_W      (CW)
  ) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .chan_i       (chan_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .result_chan_o(result_chan_o),
    .frame_o      (frame_o),
    .sck_o        (sck_o),
    .sdi_o        (sdi_o),
    .sdo_i        (sdo_i)
  );

  always #(CLK_T / 2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [RW-1:0] pick_code(input bit force_en, input logic [RW-1:0] fc);
    return force_en ? fc : RW'($urandom % 4096);
  endfunction

  // behavioural converter
  bit            force_en = 1'b0;
  logic [RW-1:0] force_code = '0;
  logic [RW-1:0] cur_code = '0;
  logic [CW-1:0] cur_tag = '0;
  logic [CW-1:0] cfg_next = '0;
  logic [CW-1:0] cap_cfg = '0;
  int            cap_idx = 0;
  int            tx_idx = 0;
  int            rises = 0;
  int            frames = 0;
  bit            sdi_bad = 1'b0;
  bit            first_rise = 1'b1;
  longint        t_frise = 0;
  longint        t_rise = 0;

  always @(posedge frame_o) begin
    cur_code = pick_code(force_en, force_code);
    cur_tag  = cfg_next;
    frames++;
    t_frise  = $time;
  end

  always @(negedge frame_o) begin
    chk(($time - t_frise) == CONV * CLK_T, "R3 frame high time", $time - t_frise, CONV * CLK_T);
    tx_idx = 0;
    sdo_i  = cur_code[RW-1];
    cap_idx = 0;
    rises  = 0;
    sdi_bad = 1'b0;
    first_rise = 1'b1;
    t_rise = $time;
  end

  always @(posedge sck_o) begin
    if (!frame_o) begin
      if (cap_idx < CW) cap_cfg[CW-1-cap_idx] = sdi_o;
      else if (sdi_o) sdi_bad = 1'b1;
      cap_idx++;
      rises++;
      if (first_rise)
        chk(($time - t_rise) == HALF * CLK_T, "R4 first rise delay", $time - t_rise, HALF * CLK_T);
      else
        chk(($time - t_rise) == DIV * CLK_T, "R4 sck period", $time - t_rise, DIV * CLK_T);
      first_rise = 1'b0;
      t_rise = $time;
    end else begin
      chk(1'b0, "R3 sck high with frame", 1, 0);
    end
  end

  always @(negedge sck_o) begin
    chk(($time - t_rise) == HALF * CLK_T, "R4 sck high time", $time - t_rise, HALF * CLK_T);
    tx_idx++;
    sdo_i = (tx_idx < RW) ? cur_code[RW-1-tx_idx] : 1'b0;
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // one readout; optionally pokes start with another word while busy
  task automatic run_frame(input logic [CW-1:0] ch, input bit poke);
    logic [RW-1:0] res_before;
    frames = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    chan_i  = ch;
    @(negedge clk_i);
    start_i = 1'b0;
    chan_i  = ~ch;
    chk(frame_o && busy_o, "R2 frame up after start", {frame_o, busy_o}, 2'b11);
    if (poke) begin
      repeat (CONV + 5) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    chk(!busy_o, "R8 idle at done", busy_o, 0);
    chk(result_o == cur_code, "R6 result code", result_o, cur_code);
    chk(result_chan_o == cur_tag, "R10 result tag", result_chan_o, cur_tag);
    chk(cap_cfg == ch, "R7 word seen by converter", cap_cfg, ch);
    chk(!sdi_bad, "R7 sdi zero after word", sdi_bad, 0);
    chk(rises == RW, "R5 rise count", rises, RW);
    cfg_next = cap_cfg;
    res_before = result_o;
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk(result_o == res_before && result_chan_o == cur_tag, "R9 result held",
        result_o, res_before);
    chk(frames == 1, "R2 one frame per start", frames, 1);
    chk(!sck_o && !frame_o, "R4 idle lines low", {sck_o, frame_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk_i);
    chk(!frame_o && !sck_o && !sdi_o && !busy_o && !done_o, "R1 outputs in reset",
        {frame_o, sck_o, sdi_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(result_o == '0 && result_chan_o == '0 && !busy_o, "R1 state after reset",
        result_o, 0);
    // start ignored while busy (R2); first tag after reset is 0 (R10)
    force_en = 1'b1;
    force_code = 12'hFFF; run_frame(2'b10, 1'b1);
    force_code = 12'h000; run_frame(2'b01, 1'b0);
    force_code = 12'h800; run_frame(2'b11, 1'b1);
    force_code = 12'h001; run_frame(2'b00, 1'b0);
    force_code = 12'hA5A; run_frame(2'b11, 1'b0);
    force_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      run_frame(CW'($urandom % 4), ($urandom % 4) == 0);
      repeat ($urandom % 5) @(negedge clk_i);
    end
    finish_run();
  end
endmodule